// File: doc/BRIEF.md
# Min-Sum Check Node Core with Radix-3 Minimum Tree

This block computes the check node message of a min-sum LDPC decoder. It takes N messages in parallel. The output carries two things. Its sign is the product of all input signs. Its magnitude is the smallest input magnitude. A decoder instantiates it once for each check node it processes in a cycle, and feeds it the bit-to-check messages of that node.

The smallest magnitude comes from a tree of three-input minimum cells, so the depth is ceil(log3 N) cell levels. For N = 7 this is two levels, where pairwise comparison would take three. Each cell forms three "strictly less than" flags from ripple chains of per-bit compare cells, with no subtractors. The flags drive a two-level multiplexer. Unused tree slots hold the largest magnitude, so they never win.

The core has one register stage, with a valid/ready interface on each side:
- A message set is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output holds its value and no new input is taken.

Top module: `cn_minsum_core`

## Requirements
- R1: Every message, input and output, is 8 bits in sign-magnitude form. Bit 7 is the sign (1 means negative). Bits 6:0 are an unsigned magnitude with 4 fractional bits. Input k sits in bits 8k+7 down to 8k of `in_msgs`.
- R2: The output magnitude equals the minimum of the N input magnitudes.
- R3: The output sign equals the XOR of all N input sign bits. This holds also when the minimum magnitude is zero.
- R4: A message set accepted on a clock edge appears on `out_msg`, with `out_valid` high, right after that same edge.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_msg` does not change.
- R6: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R7: After reset, `out_valid` is low and `out_msg` is zero.
- R8: When the output is consumed and no input is offered in that cycle, `out_valid` goes low on the next edge.
- R9: When N is not a power of three, the padding slots never affect the result. This holds even when every real input has the largest magnitude, 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input message set is valid |
| in_ready | output | 1 | Core can accept a message set |
| in_msgs | input | N*8 | N sign-magnitude messages, message k in bits 8k+7:8k |
| out_valid | output | 1 | Output message is valid |
| out_ready | input | 1 | Downstream takes the output |
| out_msg | output | 8 | Sign-magnitude check node result |

## Verification
A compare chain with a wrong bit cell or a swapped flag makes the tree pick a magnitude that is not the smallest. This shows on `out_msg` in the cycle after acceptance, but only for operand pairs that reach that bit or that cell position. For that reason the two-input configuration is swept over every pair of magnitudes. The seven-input configuration gets ties, zeros and all-maximum sets. A padding slot that leaks would show as a magnitude below 127 when all four inputs of the four-input configuration are at 127. A handshake error shows within one cycle as a lost, repeated or changing result during a stall.

// File: rtl/cn_pkg.sv
package cn_pkg;
  localparam int MSG_W = 8;
  localparam int MAG_W = MSG_W - 1;

  // number of radix-3 levels needed to cover n leaves
  function automatic int clog3(input int n);
    int lv;
    int span;
    lv = 0;
    span = 1;
    while (span < n) begin
      span = span * 3;
      lv = lv + 1;
    end
    return lv;
  endfunction

  function automatic int pow3(input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * 3;
    return r;
  endfunction
endpackage

// File: rtl/cn_mag_lt.sv
// Strict less-than from a ripple of per-bit compare cells (no subtractor).
module cn_mag_lt #(
  parameter int W = 7
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_lt_b
);
  logic [W:0] lt_chain;

  assign lt_chain[0] = 1'b0;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      // a higher bit that differs decides, otherwise the lower result carries on
      assign lt_chain[i+1] = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & lt_chain[i]);
    end
  endgenerate

  assign a_lt_b = lt_chain[W];
endmodule

// File: rtl/cn_min3.sv
// Three-input minimum cell: three flags, two-level mux, lower index wins ties.
module cn_min3 #(
  parameter int W = 7
) (
  input  logic [W-1:0] d1,
  input  logic [W-1:0] d2,
  input  logic [W-1:0] d3,
  output logic [W-1:0] dmin
);
  logic f_21;  // d2 < d1
  logic f_32;  // d3 < d2
  logic f_31;  // d3 < d1

  cn_mag_lt #(.W(W)) u_lt21 (.a(d2), .b(d1), .a_lt_b(f_21));
  cn_mag_lt #(.W(W)) u_lt32 (.a(d3), .b(d2), .a_lt_b(f_32));
  cn_mag_lt #(.W(W)) u_lt31 (.a(d3), .b(d1), .a_lt_b(f_31));

  logic [W-1:0] pick_d1_side;
  logic [W-1:0] pick_d2_side;

  always_comb begin
    pick_d1_side = f_31 ? d3 : d1;
    pick_d2_side = f_32 ? d3 : d2;
    dmin         = f_21 ? pick_d2_side : pick_d1_side;
  end
endmodule

// File: rtl/cn_min_tree.sv
// Radix-3 minimum tree over N magnitudes, padded with all-ones.
module cn_min_tree
  import cn_pkg::*;
#(
  parameter int N = 7,
  parameter int W = 7
) (
  input  logic [N*W-1:0] mags,
  output logic [W-1:0]   min_mag
);
  localparam int LEVELS = clog3(N);
  localparam int SLOTS  = pow3(LEVELS);

  logic [W-1:0] node [0:LEVELS][0:SLOTS-1];

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_leaf
      if (s < N) begin : g_real
        assign node[0][s] = mags[s*W +: W];
      end else begin : g_pad
        assign node[0][s] = '1;
      end
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      for (genvar j = 0; j < SLOTS; j++) begin : g_node
        if (j < pow3(LEVELS - 1 - l)) begin : g_cell
          cn_min3 #(.W(W)) u_min3 (
            .d1  (node[l][3*j]),
            .d2  (node[l][3*j+1]),
            .d3  (node[l][3*j+2]),
            .dmin(node[l+1][j])
          );
        end else begin : g_idle
          assign node[l+1][j] = '1;
        end
      end
    end
  endgenerate

  assign min_mag = node[LEVELS][0];
endmodule

// File: rtl/cn_minsum_core.sv
module cn_minsum_core
  import cn_pkg::*;
#(
  parameter int N = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [N*MSG_W-1:0] in_msgs,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [MSG_W-1:0]   out_msg
);
  logic [N-1:0]       signs;
  logic [N*MAG_W-1:0] mags;
  logic [MAG_W-1:0]   min_mag;
  logic               sign_prod;

  generate
    for (genvar k = 0; k < N; k++) begin : g_split
      assign signs[k]              = in_msgs[k*MSG_W + MAG_W];
      assign mags[k*MAG_W +: MAG_W] = in_msgs[k*MSG_W +: MAG_W];
    end
  endgenerate

  assign sign_prod = ^signs;

  cn_min_tree #(.N(N), .W(MAG_W)) u_tree (
    .mags   (mags),
    .min_mag(min_mag)
  );

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msg   <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_msg <= {sign_prod, min_mag};
    end
  end
endmodule

// File: rtl/cn_minsum_core_chk.sv
module cn_minsum_core_chk
  import cn_pkg::*;
#(
  parameter int N = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [N*MSG_W-1:0] in_msgs,
  input logic               out_valid,
  input logic               out_ready,
  input logic [MSG_W-1:0]   out_msg
);
  logic sign_acc;
  always_comb begin
    sign_acc = 1'b0;
    for (int k = 0; k < N; k++) sign_acc = sign_acc ^ in_msgs[k*MSG_W + MAG_W];
  end

  generate
    for (genvar k = 0; k < N; k++) begin : g_bound
      AST_MAG_NOT_ABOVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_msg[MAG_W-1:0] <= $past(in_msgs[k*MSG_W +: MAG_W]))); // R2
    end
  endgenerate

  AST_SIGN_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_msg[MAG_W] == $past(sign_acc))); // R3
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_msg))); // R5
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R6
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R8
endmodule

bind cn_minsum_core cn_minsum_core_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_msgs  (in_msgs),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_msg  (out_msg)
);

// File: tb/cn_minsum_core_bench.sv
`timescale 1ns/1ps
module cn_minsum_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        in_valid = 1'b0;
  logic        out_ready = 1'b1;
  logic [55:0] vec = '0;

  logic       rdy7, rdy4, rdy2;
  logic       ov7, ov4, ov2;
  logic [7:0] om7, om4, om2;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  cn_minsum_core #(.N(7)) u_cn_minsum_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy7),
    .in_msgs(vec), .out_valid(ov7), .out_ready(out_ready), .out_msg(om7));
  cn_minsum_core #(.N(4)) u_n4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy4),
    .in_msgs(vec[31:0]), .out_valid(ov4), .out_ready(out_ready), .out_msg(om4));
  cn_minsum_core #(.N(2)) u_n2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy2),
    .in_msgs(vec[15:0]), .out_valid(ov2), .out_ready(out_ready), .out_msg(om2));

  // R1 format: sign bit 7, magnitude bits 6:0, message k at 8k
  function automatic logic [7:0] ref_cn(input logic [55:0] v, input int n);
    logic       s;
    logic [6:0] m;
    s = 1'b0;
    m = 7'h7f;
    for (int i = 0; i < n; i++) begin
      s = s ^ v[i*8+7];
      if (v[i*8 +: 7] < m) m = v[i*8 +: 7];
    end
    return {s, m};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_one(input logic [55:0] v, input string req);
    @(negedge clk);
    vec = v;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R4 valid n7"}, {7'd0, ov7}, 8'd1);
    chk({req, " n7"}, om7, ref_cn(v, 7));
    chk({req, " n4"}, om4, ref_cn(v, 4));
    chk({req, " n2"}, om2, ref_cn(v, 2));
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [55:0] v;
    logic [55:0] a_vec;
    logic [55:0] b_vec;
    void'($urandom(13));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    chk("R7 out_valid", {7'd0, ov7}, 8'd0);
    chk("R7 out_msg", om7, 8'd0);
    rst_n = 1'b1;

    // R9 padding never wins: all real inputs at 127
    push_one({7{8'h7f}}, "R9 all max");
    push_one({8'h7f, 8'hff, 8'h7f, 8'hff, 8'hff, 8'h7f, 8'h7f}, "R9 all max mixed sign");

    // R3 zero minimum keeps sign product
    push_one({8'h11, 8'h22, 8'h33, 8'h40, 8'h55, 8'h66, 8'h80}, "R3 zero neg");
    push_one({8'h11, 8'h22, 8'h33, 8'hc0, 8'h55, 8'h66, 8'h00}, "R3 zero pos");

    // R2 R3 exhaustive magnitude pairs on the two-input instance
    for (int a = 0; a < 128; a++) begin
      for (int b = 0; b < 128; b++) begin
        v = {$urandom, $urandom};
        v[6:0]  = 7'(a);
        v[14:8] = 7'(b);
        v[7]    = 1'(a ^ b);
        v[15]   = 1'(b);
        push_one(v, "R2 R3 pair sweep");
      end
    end

    // R2 R3 varied patterns: random, ties, zeros, saturated
    for (int k = 0; k < 4000; k++) begin
      v = {$urandom, $urandom};
      for (int i = 0; i < 7; i++) begin
        case (k % 4)
          1: v[i*8 +: 7] = 7'($urandom_range(0, 3));
          2: v[i*8 +: 7] = 7'h7f;
          default: ;
        endcase
      end
      if (k % 4 == 3) v[($urandom_range(0, 6))*8 +: 7] = 7'd0;
      push_one(v, "R2 R3 pattern");
    end

    // R5 R6 back-pressure
    a_vec = {8'h12, 8'h9a, 8'h34, 8'h56, 8'h78, 8'h21, 8'h43};
    b_vec = {8'h05, 8'h7e, 8'h86, 8'h44, 8'h3c, 8'h1f, 8'h2a};
    @(negedge clk);
    out_ready = 1'b0;
    vec = a_vec;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vec = b_vec;
    chk("R6 in_ready low while stalled", {7'd0, rdy7}, 8'd0);
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R5 held valid", {7'd0, ov7}, 8'd1);
      chk("R5 held value", om7, ref_cn(a_vec, 7));
    end
    out_ready = 1'b1;
    #1;
    chk("R6 in_ready with out_ready", {7'd0, rdy7}, 8'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 next set after stall", om7, ref_cn(b_vec, 7));
    @(posedge clk);
    @(negedge clk);
    // R8 drained with no new input
    chk("R8 out_valid drops", {7'd0, ov7}, 8'd0);
    chk("R6 in_ready when empty", {7'd0, rdy7}, 8'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule